// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches a group of external interrupt request pins (eight by default) and keeps one status flag per pin. Each pin has its own sense setting: low level, falling edge, rising edge or both edges. Pins pass through a two-flop synchronizer before any edge is detected. When the selected condition is seen, the pin's flag is set. A flag that is set and enabled drives the single interrupt request line toward the CPU.

Software reaches three registers over a simple bus: the enable register, the status register and the sense register. Reads return data one cycle after the request. A flag cannot be set by software. It is cleared in one of two ways. The first is a read that returns the flag as 1, followed by a write of 0 to it. The second is an acknowledge from the CPU that carries the pin number. For an edge-sensed pin, the acknowledge always clears the flag. For a level-sensed pin, it clears the flag only if the synchronized pin is high at that moment.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, the enable, status and sense registers read as 0 and `cpu_irq` is low.
- R2: `cpu_irq` is high exactly when some pin n has its status flag set and enable bit n (at address 0, bit n) set. With all enable bits clear, the output stays low.
- R3: Sense code 2'b00 (level) sets flag n in every cycle where the synchronized pin n is low.
- R4: Sense code 2'b01 sets flag n on a high-to-low transition of the synchronized pin. A low-to-high transition does not set it.
- R5: Sense code 2'b10 sets flag n on a low-to-high transition. A high-to-low transition does not set it.
- R6: Sense code 2'b11 sets flag n on a transition in either direction.
- R7: A write to the status register (address 1) leaves any flag whose bit is written as 1 unchanged.
- R8: Writing 0 to a set flag clears it only if a status read has returned that flag as 1 since the flag was last set. Without such a read, the flag stays set.
- R9: An acknowledge of pin n in level mode clears flag n only when the synchronized pin n is high. While the pin is low, the flag stays set.
- R10: An acknowledge of pin n in any edge mode clears flag n.
- R11: When a sense event and a clearing write to the same flag happen in the same cycle, the flag stays set.
- R12: The register map is: address 0 for enable, 1 for status, 2 for sense. The sense register holds pin n's code in bits [2n+1:2n]. `bus_rvalid` is high, with the read data, in the cycle after each read request and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin | input | N_IRQ | External request pins, asynchronous |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_num | input | clog2(N_IRQ) | Number of the pin being acknowledged |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume the pins are idle high while reset is applied, so the synchronizer reset value does not create a false transition. They also assume that `ack_num` names a valid pin whenever `ack_valid` is high, and that bus requests last one cycle each. The stimulus meets all three conditions. It changes pins only on falling clock edges and holds each level well beyond the synchronizer delay. The one exception is the set-versus-clear collision, where a write is timed to land in the cycle the detected edge appears.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

   localparam logic [1:0] ADDR_ENABLE = 2'd0;
   localparam logic [1:0] ADDR_STATUS = 2'd1;
   localparam logic [1:0] ADDR_SENSE  = 2'd2;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int   WIDTH  = 8,
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("extirq_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{IDLE}};
         else        chain_q <= {chain_q[STAGES-2:0], d[i]};
      end
      assign q[i] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/extirq_sense.sv
module extirq_sense
   import extirq_pkg::*;
#(
   parameter logic IDLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [1:0] mode,
   output logic       event_o
);
   logic lvl_d;
   logic fell, rose;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= IDLE;
      else        lvl_d <= lvl;
   end

   assign fell = lvl_d & ~lvl;
   assign rose = ~lvl_d & lvl;

   always_comb begin
      unique case (mode)
         SENSE_LOW:  event_o = ~lvl;
         SENSE_FALL: event_o = fell;
         SENSE_RISE: event_o = rose;
         default:    event_o = fell | rose;
      endcase
   end

   p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != SENSE_LOW && event_o) |-> (lvl != $past(lvl)));
endmodule

// File: rtl/extirq_flag.sv
module extirq_flag
   import extirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_ev,
   input  logic       rd_stat,
   input  logic       wr_stat,
   input  logic       wbit,
   input  logic       ack_hit,
   input  logic [1:0] mode,
   input  logic       lvl,
   output logic       flag_q
);
   logic mark_q;
   logic clr_wr, clr_ack, clr_any;

   assign clr_wr  = wr_stat & ~wbit & mark_q;
   assign clr_ack = ack_hit & ((mode != SENSE_LOW) | lvl);
   assign clr_any = clr_wr | clr_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         mark_q <= 1'b0;
      end else begin
         if (set_ev)       flag_q <= 1'b1;
         else if (clr_any) flag_q <= 1'b0;

         if (set_ev || clr_any)     mark_q <= 1'b0;
         else if (rd_stat && flag_q) mark_q <= 1'b1;
      end
   end

   p_set_only_by_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(set_ev));
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev |=> flag_q);
   p_write_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_stat && wbit && !ack_hit) |=> flag_q);
   p_unarmed_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && wr_stat && !mark_q && !ack_hit) |=> flag_q);
   p_edge_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && mode != SENSE_LOW && !set_ev) |=> !flag_q);
   p_low_ack_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && mode == SENSE_LOW && !lvl) |=> flag_q);
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
   import extirq_pkg::*;
#(
   parameter int   N_IRQ       = 8,
   parameter int   DATA_W      = 16,
   parameter int   SYNC_STAGES = 2,
   parameter logic PIN_IDLE    = 1'b1,
   localparam int  ACK_W       = $clog2(N_IRQ),
   localparam int  SENSE_W     = 2 * N_IRQ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IRQ-1:0]  irq_pin,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic              ack_valid,
   input  logic [ACK_W-1:0]  ack_num,
   output logic              cpu_irq
);
   if (N_IRQ < 2) begin : g_bad_n
      $error("extirq_ctrl: N_IRQ must be at least 2");
   end
   if (DATA_W < SENSE_W) begin : g_bad_w
      $error("extirq_ctrl: DATA_W must hold two bits per pin");
   end

   logic [N_IRQ-1:0]   en_q;
   logic [SENSE_W-1:0] sense_q;
   logic [N_IRQ-1:0]   flags;
   logic [N_IRQ-1:0]   lvl;
   logic [N_IRQ-1:0]   evt;
   logic [DATA_W-1:0]  rd_mux;
   logic               rd_req, wr_req, rd_stat, wr_stat;

   assign rd_req  = bus_sel & ~bus_wr;
   assign wr_req  = bus_sel & bus_wr;
   assign rd_stat = rd_req & (bus_addr == ADDR_STATUS);
   assign wr_stat = wr_req & (bus_addr == ADDR_STATUS);

   extirq_sync #(.WIDTH(N_IRQ), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pin),
      .q     (lvl)
   );

   for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
      logic [1:0] mode;
      logic       ack_hit;
      assign mode    = sense_q[2*i +: 2];
      assign ack_hit = ack_valid & (ack_num == ACK_W'(i));

      extirq_sense #(.IDLE(PIN_IDLE)) u_sense (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl     (lvl[i]),
         .mode    (mode),
         .event_o (evt[i])
      );

      extirq_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_ev  (evt[i]),
         .rd_stat (rd_stat),
         .wr_stat (wr_stat),
         .wbit    (bus_wdata[i]),
         .ack_hit (ack_hit),
         .mode    (mode),
         .lvl     (lvl[i]),
         .flag_q  (flags[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         sense_q <= '0;
      end else if (wr_req) begin
         if (bus_addr == ADDR_ENABLE) en_q    <= bus_wdata[N_IRQ-1:0];
         if (bus_addr == ADDR_SENSE)  sense_q <= bus_wdata[SENSE_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (bus_addr)
         ADDR_ENABLE: rd_mux[N_IRQ-1:0]   = en_q;
         ADDR_STATUS: rd_mux[N_IRQ-1:0]   = flags;
         ADDR_SENSE:  rd_mux[SENSE_W-1:0] = sense_q;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_req;
         if (rd_req) bus_rdata <= rd_mux;
      end
   end

   assign cpu_irq = |(flags & en_q);

   p_rvalid_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid);
   p_rvalid_only_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid);
   p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !cpu_irq);
   p_ack_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> (int'(ack_num) < N_IRQ));
endmodule

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
   localparam int N = 8;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_pin = '1;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic          bus_rvalid;
   logic          ack_valid = 1'b0;
   logic [2:0]    ack_num = '0;
   logic          cpu_irq;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   always #2 clk = ~clk;

   extirq_ctrl u_extirq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .ack_valid(ack_valid), .ack_num(ack_num), .cpu_irq(cpu_irq)
   );

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
         end else begin
            automatic logic [W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic [W-1:0] e, input string t);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic ack(input logic [2:0] n);
      @(negedge clk);
      ack_valid = 1'b1; ack_num = n;
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic check_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (cpu_irq !== e) begin
         errors++;
         $display("FAIL %s: cpu_irq %b expected %b", t, cpu_irq, e);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      // R1 reset state
      check_irq(1'b0, "R1");
      bus_read(2'd0, 16'h0000, "R1 enable");
      bus_read(2'd1, 16'h0000, "R1 status");
      bus_read(2'd2, 16'h0000, "R1 sense");

      // R12 sense map: pin0 level, pin1 fall, pin2 rise, pin3 both
      bus_write(2'd2, 16'h00E4);
      bus_read(2'd2, 16'h00E4, "R12 sense readback");

      // R4 falling edge on pin1; then unarmed zero write keeps it (R8)
      irq_pin[1] = 1'b0;
      wait_cyc(4);
      bus_write(2'd1, 16'h0000);
      bus_read(2'd1, 16'h0002, "R4/R8 fall set, unarmed write");
      check_irq(1'b0, "R2 masked");
      bus_write(2'd0, 16'h0002);
      check_irq(1'b1, "R2 enabled");
      bus_read(2'd0, 16'h0002, "R12 enable readback");
      irq_pin[1] = 1'b1;
      wait_cyc(4);
      bus_write(2'd1, 16'h00FF);
      bus_read(2'd1, 16'h0002, "R7 write one no effect");
      bus_write(2'd1, 16'h0000);
      bus_read(2'd1, 16'h0000, "R8 armed zero write clears");
      check_irq(1'b0, "R2 cleared");
      bus_write(2'd0, 16'h0000);

      // R5 rising on pin2
      irq_pin[2] = 1'b0;
      wait_cyc(4);
      bus_read(2'd1, 16'h0000, "R5 fall ignored");
      irq_pin[2] = 1'b1;
      wait_cyc(4);
      bus_read(2'd1, 16'h0004, "R5 rise set");
      ack(3'd2);
      bus_read(2'd1, 16'h0000, "R10 ack rise");

      // R6 both edges on pin3
      irq_pin[3] = 1'b0;
      wait_cyc(4);
      bus_read(2'd1, 16'h0008, "R6 fall set");
      ack(3'd3);
      bus_read(2'd1, 16'h0000, "R10 ack both");
      irq_pin[3] = 1'b1;
      wait_cyc(4);
      bus_read(2'd1, 16'h0008, "R6 rise set");
      ack(3'd3);

      // R3/R9 level on pin0
      irq_pin[0] = 1'b0;
      wait_cyc(4);
      bus_read(2'd1, 16'h0001, "R3 level set");
      ack(3'd0);
      bus_read(2'd1, 16'h0001, "R9 ack while low");
      irq_pin[0] = 1'b1;
      wait_cyc(4);
      bus_read(2'd1, 16'h0001, "R9 flag held after release");
      ack(3'd0);
      bus_read(2'd1, 16'h0000, "R9 ack while high");

      // R11 set beats clear: arm pin1 flag, then collide write with new fall
      irq_pin[1] = 1'b0;
      wait_cyc(4);
      irq_pin[1] = 1'b1;
      wait_cyc(4);
      bus_read(2'd1, 16'h0002, "R11 setup");
      @(negedge clk);
      irq_pin[1] = 1'b0;
      @(negedge clk);
      bus_write(2'd1, 16'h0000);
      bus_read(2'd1, 16'h0002, "R11 set wins");
      irq_pin[1] = 1'b1;

      wait_cyc(3);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R12: %0d reads unanswered, expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule